// File: doc/BRIEF.md
# Burst-Aware Shared-Bus Arbiter

This block chooses which of several masters owns a shared AHB bus. Each master raises a request line, and it may also raise a lock line. The arbiter watches the transfer type, burst type, master-lock and ready signals on the shared bus. From these it drives a one-hot grant vector, an address-phase owner number for the address multiplexer and a data-phase owner number for the write-data multiplexer. The address-phase owner register is the grant itself. When it changes, the new master's address phase runs during the outgoing master's last data phase.

Ownership can only change at a clock edge where ready is high. At such an edge the arbiter keeps the current owner in three cases: a fixed-length burst still has beats to issue, an undefined-length burst is running and its master still requests, or a locked sequence is active. In every other case the next owner is chosen round-robin. The search starts from the master after the current owner. When nobody requests, master 0 owns the bus and drives IDLE. The interface has no data stream, so all pins are plain control signals. None of them has back-pressure beyond the bus ready signal.

Top module: `ahb_burst_arbiter`

## Requirements
- R1: While reset is low and after it is released, master 0 owns the bus: address owner 0, data owner 0, grant 0b0001.
- R2: At a free ready-high edge, the new owner is the first requesting master found when counting upward from the current owner plus one, wrapping at the top. The current owner is chosen only if no other master requests. Transfer codes: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ.
- R3: At a free ready-high edge with no requests, master 0 becomes owner.
- R4: A NONSEQ carrying a fixed-length burst code holds ownership until the address phase of its last beat. This holds even if the master drops its request. Burst codes: 000 single, 001 undefined-length incrementing, 010/011 four beats, 100/101 eight beats, 110/111 sixteen beats. The owner changes at the edge that ends the last beat's address phase.
- R5: At an edge where ready is low, both owner outputs and the beat count stay unchanged. BUSY cycles do not consume a beat. Each wait state therefore delays the handover by one cycle.
- R6: During an undefined-length burst (NONSEQ with code 001, then SEQ/BUSY), ownership holds while the owning master keeps its request. It is released at the first ready-high edge after the request drops.
- R7: While the bus master-lock signal is high, or while the owner raises both its request and its lock line, ownership does not change. This overrides an ending burst.
- R8: At each ready-high edge, the data owner takes the value the address owner had before that edge.
- R9: A SINGLE transfer does not hold the bus. Arbitration proceeds at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_M | Per-master bus request |
| lock | input | NUM_M | Per-master locked-access request |
| htrans | input | 2 | Shared-bus transfer type |
| hburst | input | 3 | Shared-bus burst type |
| hmastlock | input | 1 | Shared-bus locked-sequence indicator |
| hready | input | 1 | Shared-bus ready, high when the data phase completes |
| grant | output | NUM_M | One-hot grant, bit i set when master i owns the address phase |
| addr_owner | output | $clog2(NUM_M) | Master number steering the address multiplexer |
| data_owner | output | $clog2(NUM_M) | Master number steering the write-data multiplexer |

## Verification
Two decisions can collide in one cycle. The first is the end of a fixed burst, where the counter reaches zero. The second is either a bus lock that is still high or a wait state. The bench sets up both collisions deliberately. In one test the last beat's address phase is first presented with ready low and then with ready high; the owner must move only at the second edge. In another test a SINGLE transfer is issued under an active lock while other masters request; the owner must stay until the lock falls, and then rotate to the expected master.

// File: rtl/ahb_arb_pkg.sv
package ahb_arb_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  localparam int MAX_BEATS = 16;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);

  // Beat count of a fixed-length burst code; undefined length yields 0.
  function automatic logic [CNT_W-1:0] fixed_beats(input logic [2:0] code);
    logic [CNT_W-1:0] n;
    case (code[2:1])
      2'b00:   n = code[0] ? CNT_W'(0) : CNT_W'(1);
      2'b01:   n = CNT_W'(4);
      2'b10:   n = CNT_W'(8);
      default: n = CNT_W'(16);
    endcase
    return n;
  endfunction

  function automatic logic is_open_incr(input logic [2:0] code);
    return code == 3'b001;
  endfunction

endpackage

// File: rtl/ahb_arb_beat_track.sv
module ahb_arb_beat_track
  import ahb_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] htrans,
  input  logic [2:0] hburst,
  input  logic       hready,
  input  logic       owner_req,
  output logic       burst_hold
);

  logic [CNT_W-1:0] left_q, left_d;
  logic             open_q, open_d;

  // Value the counters will take if the present address phase is accepted.
  always_comb begin
    left_d = left_q;
    open_d = open_q;
    case (htrans)
      TR_NSEQ: begin
        open_d = is_open_incr(hburst);
        left_d = open_d ? '0 : fixed_beats(hburst) - CNT_W'(1);
      end
      TR_SEQ: begin
        left_d = (left_q == '0) ? '0 : left_q - CNT_W'(1);
      end
      TR_BUSY: begin
        left_d = left_q;
      end
      default: begin
        left_d = '0;
        open_d = 1'b0;
      end
    endcase
    burst_hold = (left_d != '0) || (open_d && owner_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      open_q <= 1'b0;
    end else if (hready) begin
      left_q <= left_d;
      open_q <= open_d;
    end
  end

endmodule

// File: rtl/ahb_arb_rr_pick.sv
module ahb_arb_rr_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] last,
  output logic [W-1:0] pick
);

  // Walk downward so the nearest candidate after 'last' is written last.
  always_comb begin
    logic [W-1:0] idx;
    pick = '0;
    for (int k = N; k >= 1; k--) begin
      idx = W'((int'(last) + k) % N);
      if (req[idx]) pick = idx;
    end
  end

endmodule

// File: rtl/ahb_burst_arbiter.sv
module ahb_burst_arbiter
  import ahb_arb_pkg::*;
#(
  parameter  int NUM_M = 4,
  localparam int MW    = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_M-1:0] req,
  input  logic [NUM_M-1:0] lock,
  input  logic [1:0]       htrans,
  input  logic [2:0]       hburst,
  input  logic             hmastlock,
  input  logic             hready,
  output logic [NUM_M-1:0] grant,
  output logic [MW-1:0]    addr_owner,
  output logic [MW-1:0]    data_owner
);

  logic [MW-1:0] own_q, dat_q, next_own;
  logic          burst_hold, lock_hold, keep;

  ahb_arb_beat_track beats_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .htrans     (htrans),
    .hburst     (hburst),
    .hready     (hready),
    .owner_req  (req[own_q]),
    .burst_hold (burst_hold)
  );

  ahb_arb_rr_pick #(.N(NUM_M), .W(MW)) pick_i (
    .req  (req),
    .last (own_q),
    .pick (next_own)
  );

  assign lock_hold = hmastlock || (lock[own_q] && req[own_q]);
  assign keep      = lock_hold || burst_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0;
      dat_q <= '0;
    end else if (hready) begin
      dat_q <= own_q;
      if (!keep) own_q <= next_own;
    end
  end

  for (genvar g = 0; g < NUM_M; g++) begin : g_grant
    assign grant[g] = (own_q == MW'(g));
  end

  assign addr_owner = own_q;
  assign data_owner = dat_q;

endmodule

// File: rtl/ahb_burst_arbiter_chk.sv
module ahb_burst_arbiter_chk #(
  parameter int NUM_M = 4,
  parameter int MW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NUM_M-1:0] req,
  input logic [1:0]       htrans,
  input logic [2:0]       hburst,
  input logic             hmastlock,
  input logic             hready,
  input logic [NUM_M-1:0] grant,
  input logic [MW-1:0]    addr_owner,
  input logic [MW-1:0]    data_owner
);

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1);

  // R3
  idle_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && req == '0 && !hmastlock && htrans == 2'b00) |=> addr_owner == '0);

  // R4
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans == 2'b10 && hburst[2:1] != 2'b00) |=> $stable(addr_owner));

  // R5
  wait_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> ($stable(addr_owner) && $stable(data_owner)));

  // R7
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && hmastlock) |=> $stable(addr_owner));

  // R8
  data_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hready |=> data_owner == $past(addr_owner));

endmodule

bind ahb_burst_arbiter ahb_burst_arbiter_chk #(.NUM_M(NUM_M), .MW(MW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .htrans     (htrans),
  .hburst     (hburst),
  .hmastlock  (hmastlock),
  .hready     (hready),
  .grant      (grant),
  .addr_owner (addr_owner),
  .data_owner (data_owner)
);

// File: tb/ahb_burst_arbiter_tb.sv
module ahb_burst_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0, lock = '0, grant;
  logic [1:0] htrans = 2'b00;
  logic [2:0] hburst = 3'b000;
  logic       hmastlock = 1'b0, hready = 1'b1;
  logic [1:0] addr_owner, data_owner;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [1:0] IDLE = 2'b00, BUSY = 2'b01, NSEQ = 2'b10, SEQ = 2'b11;

  always #5 clk = ~clk;

  ahb_burst_arbiter #(.NUM_M(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .htrans(htrans),
    .hburst(hburst), .hmastlock(hmastlock), .hready(hready), .grant(grant),
    .addr_owner(addr_owner), .data_owner(data_owner)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [3:0] r, input logic [1:0] t,
                       input logic [2:0] b, input logic rdy);
    req = r; htrans = t; hburst = b; hready = rdy;
  endtask

  task automatic to_owner(input int m);
    hmastlock = 1'b0; lock = '0;
    drive(4'(1 << m), IDLE, 3'b000, 1'b1);
    step();
    check("R2 setup owner", addr_owner, m);
  endtask

  task automatic t_reset();
    #2;
    check("R1 owner in reset", addr_owner, 0);
    check("R1 grant in reset", grant, 1);
    step(); rst_n = 1'b1; step();
    check("R1 owner after reset", addr_owner, 0);
    check("R1 data owner after reset", data_owner, 0);
  endtask

  task automatic t_rotation();
    to_owner(0);
    drive(4'b1010, IDLE, 3'b000, 1'b1);
    step(); check("R2 rotate to 1", addr_owner, 1);
    check("R2 grant one-hot", grant, 2);
    step(); check("R2 rotate to 3", addr_owner, 3);
    step(); check("R2 wrap to 1", addr_owner, 1);
    drive(4'b0000, IDLE, 3'b000, 1'b1);
    step(); check("R3 default owner", addr_owner, 0);
    check("R3 default grant", grant, 1);
  endtask

  task automatic t_fixed();
    to_owner(2);
    drive(4'b1001, NSEQ, 3'b011, 1'b1);
    step(); check("R4 hold beat1", addr_owner, 2);
    drive(4'b1001, SEQ, 3'b011, 1'b1);
    step(); check("R4 hold beat2", addr_owner, 2);
    step(); check("R4 hold beat3", addr_owner, 2);
    step(); check("R4 handover after last beat", addr_owner, 3);
    drive(4'b1000, IDLE, 3'b000, 1'b1);
    step(); check("R8 data owner follows", data_owner, 3);
  endtask

  task automatic t_wait_busy();
    to_owner(1);
    drive(4'b0100, NSEQ, 3'b010, 1'b1);
    step(); check("R5 hold after start", addr_owner, 1);
    drive(4'b0100, SEQ, 3'b010, 1'b0);
    step(); check("R5 wait holds owner", addr_owner, 1);
    check("R5 wait holds data owner", data_owner, 1);
    drive(4'b0100, SEQ, 3'b010, 1'b1);
    step(); check("R5 hold beat2", addr_owner, 1);
    drive(4'b0100, BUSY, 3'b010, 1'b1);
    step(); check("R5 busy not counted", addr_owner, 1);
    drive(4'b0100, SEQ, 3'b010, 1'b1);
    step(); check("R5 hold beat3", addr_owner, 1);
    drive(4'b0100, SEQ, 3'b010, 1'b0);
    step(); check("R5 last beat stalled", addr_owner, 1);
    drive(4'b0100, SEQ, 3'b010, 1'b1);
    step(); check("R5 late handover", addr_owner, 2);
  endtask

  task automatic t_open_incr();
    to_owner(1);
    drive(4'b0011, NSEQ, 3'b001, 1'b1);
    step(); check("R6 hold on start", addr_owner, 1);
    drive(4'b0011, SEQ, 3'b001, 1'b1);
    step(); check("R6 hold while requested", addr_owner, 1);
    drive(4'b0001, SEQ, 3'b001, 1'b1);
    step(); check("R6 release after drop", addr_owner, 0);
  endtask

  task automatic t_single();
    to_owner(0);
    drive(4'b0011, NSEQ, 3'b000, 1'b1);
    step(); check("R9 single releases", addr_owner, 1);
    to_owner(3);
    drive(4'b1000, NSEQ, 3'b000, 1'b1);
    step(); check("R9 sole requester keeps", addr_owner, 3);
  endtask

  task automatic t_lock();
    to_owner(2);
    hmastlock = 1'b1;
    drive(4'b1001, IDLE, 3'b000, 1'b1);
    step(); check("R7 bus lock holds", addr_owner, 2);
    drive(4'b1001, NSEQ, 3'b000, 1'b1);
    step(); check("R7 lock over single", addr_owner, 2);
    hmastlock = 1'b0;
    drive(4'b1001, IDLE, 3'b000, 1'b1);
    step(); check("R7 release after lock", addr_owner, 3);
    to_owner(1);
    lock = 4'b0010;
    drive(4'b0011, IDLE, 3'b000, 1'b1);
    step(); check("R7 master lock holds", addr_owner, 1);
    lock = '0;
    step(); check("R7 master lock off", addr_owner, 0);
  endtask

  initial begin
    t_reset();
    t_rotation();
    t_fixed();
    t_wait_busy();
    t_open_incr();
    t_single();
    t_lock();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule